// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a single down-counter with a small word-addressed register window and one level interrupt. Software sets a limit and a mode word. The counter then decrements once per prescaled step, where the step rate is the incoming tick rate divided by 1, 16 or 256. When the count reaches zero the block raises a pending flag. That flag drives the interrupt line whenever the interrupt-enable bit is set.

Three reload policies are available:
- **Periodic:** the count restarts from the stored limit.
- **Free-running:** the count wraps through the full 16-bit or 32-bit range, whatever the limit holds.
- **One-shot:** the count stops at zero.

The limit can be changed in two ways. An immediate write reloads the count at once. A deferred write only changes the value used at the next reload. Reads of the window are combinational: `rd_data_o` is valid in the same cycle as `rd_en_i`.

The counter sequencing uses three states:
- **ST_IDLE:** the timer is disabled.
- **ST_RUN:** the timer is counting.
- **ST_EXPIRED:** a one-shot count has finished.

Their transitions are:
- *start:* ST_IDLE to ST_RUN when the enable bit is set.
- *halt:* ST_RUN or ST_EXPIRED to ST_IDLE when the enable bit is cleared.
- *expire:* ST_RUN to ST_EXPIRED on a one-shot step that ends at zero.
- *rearm:* ST_EXPIRED to ST_RUN on an immediate limit write, or when the one-shot bit is cleared.

Each state transition takes effect at the clock edge after the mode word changes.

Top module: `dn_timer`

## Requirements
- R1: After reset the mode word reads 0x20 (only interrupt enable set). The count, the limit and the pending flag read 0, and `irq_o` is low.
- R2: Mode word layout:
  - bit0 one-shot, bit1 32-bit width, bits[3:2] prescale, bit5 interrupt enable, bit6 periodic, bit7 enable; bit4 reads 0.
  - Prescale code 1 divides the tick rate by 16, code 2 divides it by 256, and codes 0 and 3 divide it by 1.
- R3: In periodic mode with limit L, each step moves the count L, L-1, ..., 0 and then back to L, so a period is L+1 steps. With L = 0, every step ends at zero.
- R4: A write to byte offset 0x00 stores the limit and sets the count to the written value at once. Offsets 0x00 and 0x18 both read the stored limit.
- R5: A write to offset 0x18 stores the limit and leaves the count unchanged. The new limit is used at the next reload.
- R6: Every step whose new count is zero sets the pending flag. Offset 0x10 reads the flag in bit0. Offset 0x14 and `irq_o` show the flag ANDed with interrupt enable.
- R7: Any write to offset 0x0C clears the pending flag. If a step ending at zero falls in the same cycle, the flag stays set.
- R8: In one-shot mode the counter stops at zero and does not reload. Only an immediate limit write, or clearing the one-shot bit, restarts it.
- R9: With the periodic and one-shot bits both clear, the count wraps from 0 to 0xFFFF in 16-bit mode and to 0xFFFFFFFF in 32-bit mode, ignoring the limit.
- R10: In 16-bit mode only bits [15:0] of the count take part, and offset 0x04 reads them zero-extended.
- R11: Control writes affect counting as follows:
  - A mode write that changes the prescale code restarts the prescaler from zero.
  - A mode write keeps the current count.
  - With enable clear, the count does not move.
- R12: The following accesses are ignored or return zero:
  - Writes to offset 0x04 are ignored.
  - Reads of offset 0x0C return 0.
  - Byte offsets above 0x18, and offsets that are not a multiple of 4, read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-rate enable, one tick per cycle when high |
| addr_i | input | ADDR_W (8) | Byte address within the register window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W (32) | Read data, zero when no read or an unmapped offset |
| irq_o | output | 1 | Level interrupt: pending flag AND interrupt enable |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 16-bit narrow width, an 8-bit address window and prescale shifts of 4 and 8. Periodic limits 0 through 8 are swept step by step against the arithmetic sequence L - (k mod (L+1)). All four prescale codes are timed to the exact tick of their first step, which makes the divide-by-256 path and its wrap of the 8-bit prescaler reachable. The 32-bit width puts both free-running wrap values and the zero-extension of the 16-bit count within reach.

// File: rtl/dn_timer_pkg.sv
package dn_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } run_state_t;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic       ie;
        logic       rsvd;
        logic [1:0] presc;
        logic       wide;
        logic       oneshot;
    } mode_word_t;

    localparam int OFS_LIMIT_NOW   = 0;
    localparam int OFS_COUNT       = 1;
    localparam int OFS_MODE        = 2;
    localparam int OFS_ACK         = 3;
    localparam int OFS_PEND_RAW    = 4;
    localparam int OFS_PEND_MSK    = 5;
    localparam int OFS_LIMIT_DEFER = 6;

    localparam logic [7:0] MODE_RESET    = 8'h20;
    localparam logic [7:0] MODE_WR_MASK  = 8'hEF;

endpackage

// File: rtl/dn_timer_regs.sv
module dn_timer_regs
    import dn_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] cnt_view_i,
    input  logic              hit_i,
    output mode_word_t        mode_o,
    output logic [DATA_W-1:0] limit_o,
    output logic              load_now_o,
    output logic              presc_restart_o,
    output logic              raw_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word_idx;
    logic              aligned;
    logic              sel_now, sel_mode, sel_ack, sel_defer;
    mode_word_t        mode_q;
    logic [DATA_W-1:0] limit_q;
    logic              raw_q;

    assign word_idx  = addr_i[ADDR_W-1:2];
    assign aligned   = (addr_i[1:0] == 2'b00);
    assign sel_now   = aligned && (word_idx == IDX_W'(OFS_LIMIT_NOW));
    assign sel_mode  = aligned && (word_idx == IDX_W'(OFS_MODE));
    assign sel_ack   = aligned && (word_idx == IDX_W'(OFS_ACK));
    assign sel_defer = aligned && (word_idx == IDX_W'(OFS_LIMIT_DEFER));

    assign load_now_o      = wr_en_i && sel_now;
    assign presc_restart_o = wr_en_i && sel_mode && (wr_data_i[3:2] != mode_q.presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= mode_word_t'(MODE_RESET);
            limit_q <= '0;
        end else if (wr_en_i) begin
            if (sel_mode) begin
                mode_q <= mode_word_t'(wr_data_i[7:0] & MODE_WR_MASK);
            end
            if (sel_now || sel_defer) begin
                limit_q <= wr_data_i;
            end
        end
    end

    // Pending flag: a zero-reaching step outranks a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (hit_i) begin
            raw_q <= 1'b1;
        end else if (wr_en_i && sel_ack) begin
            raw_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i && aligned) begin
            case (word_idx)
                IDX_W'(OFS_LIMIT_NOW),
                IDX_W'(OFS_LIMIT_DEFER): rd_data_o = limit_q;
                IDX_W'(OFS_COUNT):       rd_data_o = cnt_view_i;
                IDX_W'(OFS_MODE):        rd_data_o = {{(DATA_W-8){1'b0}}, mode_q};
                IDX_W'(OFS_PEND_RAW):    rd_data_o = {{(DATA_W-1){1'b0}}, raw_q};
                IDX_W'(OFS_PEND_MSK):    rd_data_o = {{(DATA_W-1){1'b0}}, raw_q & mode_q.ie};
                default:                 rd_data_o = '0;
            endcase
        end
    end

    assign mode_o  = mode_q;
    assign limit_o = limit_q;
    assign raw_o   = raw_q;
    assign irq_o   = raw_q & mode_q.ie;

endmodule

// File: rtl/dn_timer_presc.sv
module dn_timer_presc #(
    parameter int SH_MID = 4,
    parameter int SH_HI  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic [1:0] code_i,
    input  logic       restart_i,
    output logic       step_o
);

    localparam int PRE_W = SH_HI;
    localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << SH_MID) - 1);
    localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << SH_HI) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        case (code_i)
            2'd1:    lim = LIM_MID;
            2'd2:    lim = LIM_HI;
            default: lim = '0;
        endcase
    end

    assign at_lim = (pre_q == lim);
    assign step_o = run_i && tick_i && at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart_i) begin
            pre_q <= '0;
        end else if (run_i && tick_i) begin
            pre_q <= at_lim ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/dn_timer_core.sv
module dn_timer_core
    import dn_timer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              periodic_i,
    input  logic              oneshot_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] limit_i,
    input  logic              load_now_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] cnt_view_o,
    output logic              hit_o,
    output logic              run_o,
    output run_state_t        state_o
);

    localparam logic [DATA_W-1:0] FULL_MASK   = '1;
    localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    run_state_t        state_q, state_d;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] mask, cnt_eff, reload_val, next_val;
    logic              free_mode, at_zero, stuck, live_step, advance, expire;

    assign mask       = wide_i ? FULL_MASK : NARROW_MASK;
    assign cnt_eff    = cnt_q & mask;
    assign free_mode  = !periodic_i && !oneshot_i;
    assign reload_val = free_mode ? mask : (limit_i & mask);
    assign at_zero    = (cnt_eff == '0);
    assign next_val   = at_zero ? reload_val : ((cnt_eff - 1'b1) & mask);
    assign stuck      = oneshot_i && at_zero;
    assign live_step  = step_i && (state_q == ST_RUN) && !load_now_i;
    assign advance    = live_step && !stuck;
    assign expire     = live_step && oneshot_i && (stuck || next_val == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, halt, expire, rearm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en_i)       state_d = ST_IDLE;
                else if (expire) state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (!en_i)                        state_d = ST_IDLE;
                else if (load_now_i || !oneshot_i) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        run_o = (state_q == ST_RUN);
        hit_o = advance && (next_val == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_now_i) begin
            cnt_q <= load_data_i;
        end else if (advance) begin
            cnt_q <= next_val;
        end else if (expire) begin
            cnt_q <= '0;
        end
    end

    assign cnt_view_o = cnt_eff;
    assign state_o    = state_q;

endmodule

// File: rtl/dn_timer.sv
module dn_timer
    import dn_timer_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int SH_MID   = 4,
    parameter int SH_HI    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    mode_word_t        mode;
    logic [DATA_W-1:0] limit;
    logic [DATA_W-1:0] cnt_view;
    logic              load_now, presc_restart, raw, hit, step, run;
    run_state_t        state;

    dn_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .addr_i          (addr_i),
        .wr_en_i         (wr_en_i),
        .wr_data_i       (wr_data_i),
        .rd_en_i         (rd_en_i),
        .cnt_view_i      (cnt_view),
        .hit_i           (hit),
        .mode_o          (mode),
        .limit_o         (limit),
        .load_now_o      (load_now),
        .presc_restart_o (presc_restart),
        .raw_o           (raw),
        .rd_data_o       (rd_data_o),
        .irq_o           (irq_o)
    );

    dn_timer_presc #(.SH_MID(SH_MID), .SH_HI(SH_HI)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (run),
        .code_i    (mode.presc),
        .restart_i (presc_restart),
        .step_o    (step)
    );

    dn_timer_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (mode.en),
        .periodic_i  (mode.periodic),
        .oneshot_i   (mode.oneshot),
        .wide_i      (mode.wide),
        .limit_i     (limit),
        .load_now_i  (load_now),
        .load_data_i (wr_data_i),
        .step_i      (step),
        .cnt_view_o  (cnt_view),
        .hit_o       (hit),
        .run_o       (run),
        .state_o     (state)
    );

endmodule

// File: rtl/dn_timer_chk.sv
module dn_timer_chk
    import dn_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] cnt_view,
    input logic              wide,
    input logic              hit,
    input logic              step,
    input logic              raw,
    input run_state_t        state
);

    localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-16){1'b0}}, 16'hFFFF};

    logic w_now, w_count, w_mode, w_ack, w_defer;
    assign w_now   = wr_en_i && (addr_i == ADDR_W'(OFS_LIMIT_NOW * 4));
    assign w_count = wr_en_i && (addr_i == ADDR_W'(OFS_COUNT * 4));
    assign w_mode  = wr_en_i && (addr_i == ADDR_W'(OFS_MODE * 4));
    assign w_ack   = wr_en_i && (addr_i == ADDR_W'(OFS_ACK * 4));
    assign w_defer = wr_en_i && (addr_i == ADDR_W'(OFS_LIMIT_DEFER * 4));

    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        w_now |=> cnt_view == ($past(wr_data_i) & (wide ? '1 : NARROW_MASK))); // R4

    AST_DEFER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (w_defer && !step) |=> $stable(cnt_view)); // R5

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw); // R6

    AST_ONE_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state == ST_RUN && cnt_view == 1 && !w_now) |=> raw); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (w_ack && !hit) |=> !raw); // R7

    AST_EXPIRED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EXPIRED |-> cnt_view == '0); // R8

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !w_now && !w_mode) |=> $stable(cnt_view)); // R11

    AST_COUNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (w_count && !step) |=> $stable(cnt_view)); // R12

endmodule

bind dn_timer dn_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cnt_view  (cnt_view),
    .wide      (mode.wide),
    .hit       (hit),
    .step      (step),
    .raw       (raw),
    .state     (state)
);

// File: tb/tb_dn_timer.sv
`timescale 1ns/1ps
module tb_dn_timer;

    localparam logic [7:0] A_NOW   = 8'h00;
    localparam logic [7:0] A_CNT   = 8'h04;
    localparam logic [7:0] A_MODE  = 8'h08;
    localparam logic [7:0] A_ACK   = 8'h0C;
    localparam logic [7:0] A_RAW   = 8'h10;
    localparam logic [7:0] A_MSK   = 8'h14;
    localparam logic [7:0] A_DEFER = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dn_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2;
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int div;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_check("R1 mode", A_MODE, 32'h20);
        rd_check("R1 count", A_CNT, 32'h0);
        rd_check("R1 limit", A_NOW, 32'h0);
        rd_check("R1 raw", A_RAW, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R3 / R4 / R6 periodic sweep, divide by 1, 32-bit
        for (int lim = 0; lim <= 8; lim++) begin
            wr(A_MODE, 32'h22);
            wr(A_ACK, 32'h0);
            wr(A_NOW, lim);
            wr(A_MODE, 32'hE2);
            rd_check("R4 limit now", A_NOW, lim);
            rd_check("R4 limit defer", A_DEFER, lim);
            rd_check("R4 count loaded", A_CNT, lim);
            for (int k = 1; k <= 2 * lim + 3; k++) begin
                ticks(1);
                rd_check("R3 count", A_CNT, lim - (k % (lim + 1)));
                rd_check("R6 raw", A_RAW, (k >= lim) ? 32'h1 : 32'h0);
                check("R6 irq", {31'b0, irq}, (k >= lim) ? 32'h1 : 32'h0);
            end
        end

        // R2 prescale codes
        for (int code = 0; code < 4; code++) begin
            div = (code == 1) ? 16 : (code == 2) ? 256 : 1;
            wr(A_MODE, 32'h42 | (code << 2));
            wr(A_NOW, 1000);
            wr(A_MODE, 32'hC2 | (code << 2));
            ticks(div - 1);
            rd_check("R2 before first step", A_CNT, 1000);
            ticks(1);
            rd_check("R2 first step", A_CNT, 999);
            ticks(3 * div);
            rd_check("R2 three steps", A_CNT, 996);
            rd_check("R2 mode readback", A_MODE, 32'hC2 | (code << 2));
        end

        // R11 prescaler restart and enable freeze
        wr(A_MODE, 32'h46);
        wr(A_NOW, 100);
        wr(A_MODE, 32'hC6);
        ticks(10);
        rd_check("R11 partial prescale", A_CNT, 100);
        wr(A_MODE, 32'hCA);
        wr(A_MODE, 32'hC6);
        ticks(15);
        rd_check("R11 restarted prescaler", A_CNT, 100);
        ticks(1);
        rd_check("R11 step after restart", A_CNT, 99);
        wr(A_MODE, 32'h46);
        ticks(40);
        rd_check("R11 frozen when disabled", A_CNT, 99);
        wr(A_MODE, 32'hC6);
        rd_check("R11 count kept on enable", A_CNT, 99);
        ticks(16);
        rd_check("R11 continues", A_CNT, 98);

        // R5 deferred limit
        wr(A_MODE, 32'h42);
        wr(A_NOW, 5);
        wr(A_MODE, 32'hC2);
        ticks(2);
        rd_check("R5 before defer", A_CNT, 3);
        wr(A_DEFER, 9);
        rd_check("R5 count untouched", A_CNT, 3);
        rd_check("R5 limit via now", A_NOW, 9);
        ticks(3);
        rd_check("R5 reach zero", A_CNT, 0);
        ticks(1);
        rd_check("R5 reload new limit", A_CNT, 9);
        ticks(1);
        rd_check("R5 continue", A_CNT, 8);

        // R6 / R7 pending flag and masking
        wr(A_MODE, 32'h42);
        wr(A_ACK, 32'h0);
        wr(A_NOW, 0);
        wr(A_MODE, 32'hC2);
        ticks(1);
        rd_check("R6 raw set ie off", A_RAW, 32'h1);
        rd_check("R6 masked zero", A_MSK, 32'h0);
        check("R6 irq masked", {31'b0, irq}, 32'h0);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = A_ACK; wr_data = 32'h0;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd_check("R7 set wins over clear", A_RAW, 32'h1);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_check("R7 clear", A_RAW, 32'h0);
        wr(A_MODE, 32'hE2);
        ticks(1);
        rd_check("R6 masked set", A_MSK, 32'h1);
        check("R6 irq set", {31'b0, irq}, 32'h1);
        rd_check("R12 ack reads zero", A_ACK, 32'h0);
        wr(A_ACK, 32'h0);
        check("R7 irq cleared", {31'b0, irq}, 32'h0);

        // R8 one-shot
        wr(A_MODE, 32'h23);
        wr(A_ACK, 32'h0);
        wr(A_NOW, 3);
        wr(A_MODE, 32'hA3);
        ticks(3);
        rd_check("R8 reached zero", A_CNT, 0);
        rd_check("R8 raw", A_RAW, 32'h1);
        ticks(5);
        rd_check("R8 stays zero", A_CNT, 0);
        wr(A_ACK, 32'h0);
        ticks(5);
        rd_check("R8 no new flag", A_RAW, 32'h0);
        wr(A_NOW, 2);
        rd_check("R8 rearm load", A_CNT, 2);
        ticks(2);
        rd_check("R8 second expiry count", A_CNT, 0);
        rd_check("R8 second expiry raw", A_RAW, 32'h1);

        // R9 / R10 free-running
        wr(A_MODE, 32'h00);
        wr(A_ACK, 32'h0);
        wr(A_NOW, 32'h0001_0002);
        rd_check("R10 zero-extended view", A_CNT, 32'h2);
        rd_check("R10 limit full width", A_NOW, 32'h0001_0002);
        wr(A_MODE, 32'h80);
        ticks(2);
        rd_check("R9 narrow at zero", A_CNT, 0);
        ticks(1);
        rd_check("R9 narrow wrap", A_CNT, 32'hFFFF);
        ticks(1);
        rd_check("R10 narrow decrement", A_CNT, 32'hFFFE);
        wr(A_MODE, 32'h02);
        wr(A_NOW, 1);
        wr(A_MODE, 32'h82);
        ticks(2);
        rd_check("R9 wide wrap", A_CNT, 32'hFFFF_FFFF);

        // R12 ignored writes and unmapped reads
        wr(A_MODE, 32'h02);
        wr(A_NOW, 7);
        wr(A_CNT, 32'h55);
        rd_check("R12 count write ignored", A_CNT, 7);
        wr(8'h1C, 32'hAB);
        wr(8'h40, 32'hCD);
        wr(8'h01, 32'hEE);
        rd_check("R12 limit kept", A_NOW, 7);
        rd_check("R12 mode kept", A_MODE, 32'h02);
        rd_check("R12 unmapped 0x1C", 8'h1C, 32'h0);
        rd_check("R12 unmapped 0x20", 8'h20, 32'h0);
        rd_check("R12 misaligned", 8'h02, 32'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule